// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the programming state of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit test-select field. All control inputs are sampled in a single system clock domain. Every load strobe is synchronized there and its edges are detected there. The serial clock is treated as a sampled data signal, not as a clock. The dividers, the oscillator and the loop filter live elsewhere. This block only presents the values they use and a divider-clear line.

There are two ways to write the values. A parallel path follows dedicated pins while its active-low strobe is low and captures them when the strobe rises. A three-wire serial path shifts a 13-bit word into a staging register, then commits it on a rising load edge. If the load line is held high, the serial path writes straight into the live configuration. A test output is chosen from four sources by the test-select field, which only the serial path can write.

Top module: `divcfg_loader`

## Requirements
- R1: While `rst_n` is low and right after it is released, `m_val`/`n_code` equal `par_m`/`par_n`, `t_sel` is 00, and `range_err` reflects the loaded M.
- R2: While `par_load_n` is low (after synchronization), `m_val` and `n_code` follow `par_m` and `par_n`, and `test_out` is held at 0 regardless of `t_sel`.
- R3: The rising edge of `par_load_n` captures `par_m`/`par_n`. Later pin changes are ignored while `par_load_n` stays high.
- R4: The staging register shifts one `ser_data` bit per rising `ser_clk` edge only while `par_load_n` is high and `ser_load` is low. Bits arrive MSB first in the order T1, T0, N1, N0, M8..M0, so after 13 clocks M0 sits in bit 0.
- R5: A rising edge of `ser_load` (in serial mode) copies the staging word to `t_sel` = bits 12:11, `n_code` = bits 10:9, `m_val` = bits 8:0. This overrides any parallel-captured value.
- R6: With `ser_load` low in serial mode, `m_val`, `n_code` and `t_sel` stay frozen even while new bits are shifted in.
- R7: While `ser_load` stays high, each rising `ser_clk` edge shifts `ser_data` into the live 13-bit word {t_sel, n_code, m_val} at bit 0. The staging register is left untouched.
- R8: `test_out` is chosen by `t_sel` as follows: 00 gives 0, 01 gives synchronized `ser_data`, 10 gives `mdiv_in`, 11 gives `synth_in`.
- R9: Parallel loads never change `t_sel`.
- R10: `div_clear` follows `mr`. Asserting `mr` leaves `m_val`, `n_code` and `t_sel` unchanged.
- R11: `range_err` is 1 exactly when `m_val` is below 10 or above 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for sampling and all state |
| rst_n | input | 1 | Active-low power-up reset |
| mr | input | 1 | Active-high divider clear request |
| par_load_n | input | 1 | Active-low parallel load strobe |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial transfer / bypass control |
| mdiv_in | input | 1 | Feedback divider output for the test mux |
| synth_in | input | 1 | Synthesized clock for the test mux |
| m_val | output | 9 | Current feedback divide value |
| n_code | output | 2 | Current output divide code |
| t_sel | output | 2 | Current test-select field |
| test_out | output | 1 | Test multiplexer output |
| div_clear | output | 1 | Divider clear to downstream counters |
| range_err | output | 1 | M outside the lockable range |

## Verification
The assertions check these properties on every cycle. `test_out` stays low in parallel mode. `t_sel` never moves on a parallel load. The live word stays still while the serial load line is low. A serial transfer lands the exact staging word. The staging register is frozen both in parallel mode and while the load line is high. Only the bench's scenarios can show the following. The 13-bit ordering of a random word comes out in the right fields. Bypass shifting updates the live word bit by bit. Pins seen after a parallel capture are ignored. The range flag switches at 9/10 and 28/29. Each of the four test sources really reaches the output.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
   typedef enum logic [1:0] {
      TSEL_LOW   = 2'b00,
      TSEL_SDATA = 2'b01,
      TSEL_MDIV  = 2'b10,
      TSEL_SYNTH = 2'b11
   } tsel_e;

   localparam int unsigned TSEL_W = 2;

   function automatic logic out_of_range(input int unsigned val,
                                         input int unsigned lo,
                                         input int unsigned hi);
      return (val < lo) || (val > hi);
   endfunction
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
   parameter int unsigned W       = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] rise
);
   localparam int unsigned CHAIN_W = W * STAGES;

   logic [CHAIN_W-1:0] chain_q;
   logic [W-1:0]       prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
         prev_q  <= RST_VAL;
      end else begin
         chain_q <= {chain_q[CHAIN_W-W-1:0], d};
         prev_q  <= chain_q[CHAIN_W-1 -: W];
      end
   end

   assign q    = chain_q[CHAIN_W-1 -: W];
   assign rise = q & ~prev_q;
endmodule

// File: rtl/divcfg_shreg.sv
module divcfg_shreg #(
   parameter int unsigned W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (shift_en) word <= {word[W-2:0], din};
   end
endmodule

// File: rtl/divcfg_testmux.sv
module divcfg_testmux
   import divcfg_pkg::*;
(
   input  tsel_e sel,
   input  logic  force_low,
   input  logic  sdata,
   input  logic  mdiv,
   input  logic  synth,
   output logic  y
);
   always_comb begin
      y = 1'b0;
      if (!force_low) begin
         unique case (sel)
            TSEL_LOW:   y = 1'b0;
            TSEL_SDATA: y = sdata;
            TSEL_MDIV:  y = mdiv;
            TSEL_SYNTH: y = synth;
            default:    y = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
   import divcfg_pkg::*;
#(
   parameter int unsigned M_W         = 9,
   parameter int unsigned N_W         = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned M_MIN       = 10,
   parameter int unsigned M_MAX       = 28
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mr,
   input  logic           par_load_n,
   input  logic [M_W-1:0] par_m,
   input  logic [N_W-1:0] par_n,
   input  logic           ser_clk,
   input  logic           ser_data,
   input  logic           ser_load,
   input  logic           mdiv_in,
   input  logic           synth_in,
   output logic [M_W-1:0] m_val,
   output logic [N_W-1:0] n_code,
   output logic [1:0]     t_sel,
   output logic           test_out,
   output logic           div_clear,
   output logic           range_err
);
   localparam int unsigned PN_W  = N_W + M_W;
   localparam int unsigned CFG_W = TSEL_W + PN_W;
   localparam int unsigned NSIG  = 4;
   localparam int unsigned I_PL  = 3;
   localparam int unsigned I_SL  = 2;
   localparam int unsigned I_SCK = 1;
   localparam int unsigned I_SD  = 0;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("divcfg_loader: SYNC_STAGES must be at least 2");
   end
   if (M_MIN > M_MAX) begin : g_bad_range
      $error("divcfg_loader: M_MIN exceeds M_MAX");
   end
   if (M_MAX >= (1 << M_W)) begin : g_bad_mw
      $error("divcfg_loader: M_MAX does not fit in M_W bits");
   end

   logic [NSIG-1:0]  raw_in, sync_q, sync_rise;
   logic             pl_s, pl_rise, sl_s, sl_rise, sck_rise, sd_s;
   logic [CFG_W-1:0] sr_q;
   logic [CFG_W-1:0] cfg_q;
   logic             shift_en;

   assign raw_in = {par_load_n, ser_load, ser_clk, ser_data};

   divcfg_sync #(
      .W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL('0)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_q), .rise(sync_rise)
   );

   assign pl_s     = sync_q[I_PL];
   assign pl_rise  = sync_rise[I_PL];
   assign sl_s     = sync_q[I_SL];
   assign sl_rise  = sync_rise[I_SL];
   assign sck_rise = sync_rise[I_SCK];
   assign sd_s     = sync_q[I_SD];

   assign shift_en = pl_s & ~sl_s & sck_rise;

   divcfg_shreg #(.W(CFG_W)) u_sr (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(sd_s), .word(sr_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= {{TSEL_W{1'b0}}, par_n, par_m};
      end else if (!pl_s || pl_rise) begin
         cfg_q[PN_W-1:0] <= {par_n, par_m};
      end else if (sl_rise) begin
         cfg_q <= sr_q;
      end else if (sl_s && sck_rise) begin
         cfg_q <= {cfg_q[CFG_W-2:0], sd_s};
      end
   end

   assign m_val  = cfg_q[M_W-1:0];
   assign n_code = cfg_q[PN_W-1:M_W];
   assign t_sel  = cfg_q[CFG_W-1:PN_W];

   divcfg_testmux u_mux (
      .sel(tsel_e'(t_sel)), .force_low(~pl_s), .sdata(sd_s),
      .mdiv(mdiv_in), .synth(synth_in), .y(test_out)
   );

   assign div_clear = mr;
   assign range_err = out_of_range(int'(m_val), M_MIN, M_MAX);
endmodule

// File: rtl/divcfg_loader_chk.sv
module divcfg_loader_chk #(
   parameter int unsigned CFG_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pl_s,
   input logic             pl_rise,
   input logic             sl_s,
   input logic             sl_rise,
   input logic [CFG_W-1:0] sr,
   input logic [CFG_W-1:0] cfg,
   input logic             test_out
);
   a_r2_test_low_par: assert property (@(posedge clk) disable iff (!rst_n)
      !pl_s |-> (test_out == 1'b0));

   a_r9_tsel_par_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!pl_s || pl_rise) |=> $stable(cfg[CFG_W-1:CFG_W-2]));

   a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_s && !pl_rise && !sl_s) |=> $stable(cfg));

   a_r5_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_s && !pl_rise && sl_rise) |=> (cfg == $past(sr)));

   a_r4_sr_par_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !pl_s |=> $stable(sr));

   a_r7_sr_bypass_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      sl_s |=> $stable(sr));
endmodule

bind divcfg_loader divcfg_loader_chk #(.CFG_W(CFG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pl_s(pl_s), .pl_rise(pl_rise),
   .sl_s(sl_s), .sl_rise(sl_rise), .sr(sr_q), .cfg(cfg_q),
   .test_out(test_out)
);

// File: tb/sim_divcfg_loader.sv
module sim_divcfg_loader;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mr = 1'b0;
   logic       par_load_n = 1'b0;
   logic [8:0] par_m = 9'd25;
   logic [1:0] par_n = 2'd2;
   logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
   logic       mdiv_in = 1'b0, synth_in = 1'b0;
   logic [8:0] m_val;
   logic [1:0] n_code, t_sel;
   logic       test_out, div_clear, range_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [12:0] exp_cfg;
   logic [12:0] sr_model;

   always #10 clk = ~clk;

   divcfg_loader u0 (
      .clk(clk), .rst_n(rst_n), .mr(mr), .par_load_n(par_load_n),
      .par_m(par_m), .par_n(par_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_load(ser_load), .mdiv_in(mdiv_in), .synth_in(synth_in),
      .m_val(m_val), .n_code(n_code), .t_sel(t_sel), .test_out(test_out),
      .div_clear(div_clear), .range_err(range_err)
   );

   function automatic logic exp_range(input logic [8:0] m);
      return (m < 9'd10) || (m > 9'd28);
   endfunction

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_cfg(input string req);
      chk(req, {19'd0, t_sel, n_code, m_val}, {19'd0, exp_cfg});
   endtask

   task automatic par_load(input logic [8:0] m, input logic [1:0] n);
      par_load_n = 1'b0; par_m = m; par_n = n;
      step(5);
      par_load_n = 1'b1;
      step(6);
      par_m = ~m; par_n = ~n;
      step(4);
      exp_cfg[10:0] = {n, m};
   endtask

   task automatic ser_bit(input logic b);
      ser_data = b; step(5);
      ser_clk = 1'b1; step(5);
      ser_clk = 1'b0; step(5);
   endtask

   task automatic shift_word(input logic [12:0] w);
      for (int i = 12; i >= 0; i--) ser_bit(w[i]);
      sr_model = w;
   endtask

   task automatic pulse_sl();
      ser_load = 1'b1; step(6);
      ser_load = 1'b0; step(6);
      exp_cfg = sr_model;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [12:0] w;
      void'($urandom(32'd1234));
      exp_cfg = 13'd0; sr_model = 13'd0;
      step(4);
      chk("R1 reset m/n/t", {19'd0, t_sel, n_code, m_val}, {19'd0, 2'b00, 2'd2, 9'd25});
      rst_n = 1'b1;
      step(2);
      exp_cfg = {2'b00, 2'd2, 9'd25};
      chk_cfg("R1 after release");
      chk("R1 range flag", range_err, 0);

      // R2 parallel pass-through, test forced low
      mdiv_in = 1'b1; synth_in = 1'b1;
      par_m = 9'd12; par_n = 2'd1; step(3);
      exp_cfg[10:0] = {2'd1, 9'd12};
      chk_cfg("R2 follow pins");
      par_m = 9'd300; step(2);
      chk("R2 follow pins 2", m_val, 300);
      chk("R2 test low", test_out, 0);

      // R3 capture on rising strobe, later pins ignored
      par_m = 9'd20; par_n = 2'd3; step(3);
      par_load_n = 1'b1; step(6);
      par_m = 9'd5; par_n = 2'd0; step(6);
      exp_cfg[10:0] = {2'd3, 9'd20};
      chk_cfg("R3 pins ignored after capture");

      // R11 range boundaries
      par_load(9'd9, 2'd0);  chk("R11 m=9",  range_err, 1);
      par_load(9'd10, 2'd0); chk("R11 m=10", range_err, 0);
      par_load(9'd28, 2'd0); chk("R11 m=28", range_err, 0);
      par_load(9'd29, 2'd0); chk("R11 m=29", range_err, 1);
      chk_cfg("R3 par_load value");

      // R4/R5/R6 random serial words
      for (int k = 0; k < 16; k++) begin
         w = 13'($urandom);
         shift_word(w);
         chk_cfg("R6 frozen during shift");
         pulse_sl();
         chk_cfg("R5 transfer word");
         chk("R11 flag vs loaded M", range_err, exp_range(exp_cfg[8:0]));
      end

      // R9 parallel load keeps T
      exp_cfg[12:11] = t_sel;
      par_load(9'd15, 2'd1);
      chk_cfg("R9 T kept on parallel load");

      // R4 no shifting in parallel mode
      par_load_n = 1'b0; step(5);
      for (int i = 0; i < 13; i++) ser_bit(~sr_model[i]);
      par_m = 9'd17; par_n = 2'd2; step(2);
      par_load_n = 1'b1; step(6);
      pulse_sl();
      chk_cfg("R4 staging untouched in parallel mode");

      // R7 bypass shifting while load high
      w = {2'b01, 2'b10, 9'd77};
      shift_word(w);
      ser_load = 1'b1; step(6);
      exp_cfg = w;
      chk_cfg("R7 transfer on rise");
      ser_bit(1'b1); exp_cfg = {exp_cfg[11:0], 1'b1};
      ser_bit(1'b0); exp_cfg = {exp_cfg[11:0], 1'b0};
      ser_bit(1'b1); exp_cfg = {exp_cfg[11:0], 1'b1};
      chk_cfg("R7 bypass shift");
      ser_load = 1'b0; step(6);
      ser_data = 1'b0; step(3);
      chk_cfg("R6 frozen after fall");
      pulse_sl();
      chk_cfg("R7 staging untouched in bypass");

      // R8 test mux
      for (int t = 0; t < 4; t++) begin
         shift_word({2'(t), 2'd0, 9'd20});
         pulse_sl();
         chk_cfg("R8 load T");
         mdiv_in = 1'b1; synth_in = 1'b0; ser_data = 1'b0; step(5);
         chk("R8 test out a", test_out, (t == 2) ? 1 : 0);
         mdiv_in = 1'b0; synth_in = 1'b1; ser_data = 1'b1; step(5);
         chk("R8 test out b", test_out, (t == 1 || t == 3) ? 1 : 0);
      end

      // R2 parallel mode forces test low even with T=11
      par_load_n = 1'b0; par_m = 9'd22; par_n = 2'd1; step(5);
      chk("R2 test low with T=11", test_out, 0);
      par_load_n = 1'b1; step(6);
      exp_cfg[10:0] = {2'd1, 9'd22};
      chk_cfg("R9 T=11 survives parallel");

      // R10 master reset
      mr = 1'b1; step(3);
      chk("R10 div_clear high", div_clear, 1);
      chk_cfg("R10 values kept");
      mr = 1'b0; step(2);
      chk("R10 div_clear low", div_clear, 0);
      chk_cfg("R10 values kept after");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule